// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Core

This block models a synchronous SRAM with a double-rate data path. Every access moves two words. It runs from one clock `clk` at twice the access rate. An internal half selector marks each edge. The first edge after reset is an access edge (A-edge), then odd-half and A-edges alternate. A command is taken only on an A-edge. Write data come in as two half-cycle beats. Read data go out as two half-cycle beats after a latency chosen by a strap input.

A write is not put into the array at once. It waits in a holding register and is committed only when the first data beat of the next write arrives. A read that addresses either word in the holding register gets the held bytes, merged lane by lane with the array contents. So a read issued just after a write returns the newest data.

The read port is valid-qualified and has no back-pressure. Every started access must finish in its fixed slots, so the consumer must take each beat in the cycle `rd_valid` is high. The write data have no handshake. They are sampled in the fixed slots after a write command.

Top module: `burst2_ddr_sram`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `rd_valid` is 0, `rdata` is 0 and the holding register is empty.
- R2: A command is taken only on an A-edge with `start_n` low. `rd_not_wr` high means read and low means write. `start_n` low on an odd-half edge has no effect.
- R3: A burst at word address a moves word a first, then the word whose address is a with bit 0 inverted, so the burst wraps inside the aligned pair.
- R4: With `lat_half` low, the read command on edge n gives the first word on the output after edge n+2 and the second after edge n+3.
- R5: With `lat_half` high, both read beats come one edge later: after edges n+3 and n+4.
- R6: For the write command on edge n, `wdata` and `wbyte_en` are sampled on edge n+2 (first word) and edge n+3 (second word). `wbyte_en[0]` covers bits 8:0 and `wbyte_en[1]` covers bits 17:9. Bytes whose enable is 0 keep their stored value.
- R7: A write stays in the holding register and is committed to the array on the first data edge of the next write. Data committed this way are returned by later reads.
- R8: A read of either word held in the holding register returns the held bytes for enabled lanes and the array bytes for the other lanes.
- R9: `rd_valid` is high only in cycles that carry a read beat. Outside those cycles `rdata` is 0. After the last beat it falls on the next edge.
- R10: A new command may be given on every A-edge, with reads and writes mixed in any order. Each access finishes with the timing above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, two edges per access slot |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_half | input | 1 | Latency strap: 0 gives one cycle, 1 gives one and a half cycles. Change it only while idle |
| start_n | input | 1 | Active-low access strobe, sampled on A-edges |
| rd_not_wr | input | 1 | 1 means read, 0 means write |
| addr | input | AW | Word address of the first burst word |
| wdata | input | 18 | Write data beat |
| wbyte_en | input | 2 | Per-lane write enables for the current beat |
| rdata | output | 18 | Read data beat, 0 when idle |
| rd_valid | output | 1 | High in each cycle that carries a read beat |

## Verification
Full-lane writes followed later by reads check the basic store path. Odd start addresses check the word order inside a burst. Partial-lane writes are committed by a following write and then read. This separates correct lane masking from whole-word writes. Reads issued right after a partial write check that forwarding merges lane by lane rather than word by word. Back-to-back command runs, strobes on odd-half edges and both latency settings check the slot timing.

// File: rtl/b2ddr_pkg.sv
package b2ddr_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_en_t;

  function automatic word_t lane_merge(input word_t base, input word_t upd,
                                       input lane_en_t en);
    word_t r;
    r = base;
    for (int l = 0; l < int'(LANES); l++) begin
      if (en[l]) r[l*LANE_W +: LANE_W] = upd[l*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/b2ddr_cmdpipe.sv
module b2ddr_cmdpipe #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_half,
  input  logic          start_n,
  input  logic          rd_not_wr,
  input  logic [AW-1:0] addr,
  output logic          k_edge,
  output logic          rd_b0_v,
  output logic          rd_b1_v,
  output logic [AW-1:0] rd_addr,
  output logic          wr_b0_v,
  output logic          wr_b1_v,
  output logic [AW-1:0] wr_addr
);
  localparam int unsigned STAGES = 4;

  logic                 half_sel;
  logic [STAGES-1:0]    rd_sh;
  logic [STAGES-1:0]    wr_sh;
  logic [STAGES*AW-1:0] ad_sh;
  logic [AW-1:0]        b0_addr;
  logic [AW-1:0]        b1_addr;
  logic                 take;

  assign k_edge = ~half_sel;
  assign take   = k_edge & ~start_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_sel <= 1'b0;
      rd_sh    <= '0;
      wr_sh    <= '0;
      ad_sh    <= '0;
    end else begin
      half_sel <= ~half_sel;
      rd_sh    <= {rd_sh[STAGES-2:0], take & rd_not_wr};
      wr_sh    <= {wr_sh[STAGES-2:0], take & ~rd_not_wr};
      ad_sh    <= {ad_sh[(STAGES-1)*AW-1:0], addr};
    end
  end

  // stage s holds a command accepted s+1 edges ago
  assign rd_b0_v = lat_half ? rd_sh[2] : rd_sh[1];
  assign rd_b1_v = lat_half ? rd_sh[3] : rd_sh[2];
  assign b0_addr = lat_half ? ad_sh[2*AW +: AW] : ad_sh[1*AW +: AW];
  assign b1_addr = lat_half ? ad_sh[3*AW +: AW] : ad_sh[2*AW +: AW];
  assign rd_addr = rd_b0_v ? b0_addr : {b1_addr[AW-1:1], ~b1_addr[0]};

  assign wr_b0_v = wr_sh[1];
  assign wr_b1_v = wr_sh[2];
  assign wr_addr = ad_sh[1*AW +: AW];
endmodule

// File: rtl/b2ddr_array.sv
module b2ddr_array import b2ddr_pkg::*; #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wd0,
  input  lane_en_t      wbe0,
  input  word_t         wd1,
  input  lane_en_t      wbe1,
  input  logic [AW-1:0] raddr,
  output word_t         rword
);
  localparam int unsigned WORDS = 1 << AW;

  word_t         mem [WORDS];
  logic [AW-1:0] waddr_pair;

  assign waddr_pair = {waddr[AW-1:1], ~waddr[0]};
  assign rword      = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr]      <= lane_merge(mem[waddr], wd0, wbe0);
      mem[waddr_pair] <= lane_merge(mem[waddr_pair], wd1, wbe1);
    end
  end
endmodule

// File: rtl/b2ddr_hold.sv
module b2ddr_hold import b2ddr_pkg::*; #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_b0_v,
  input  logic          wr_b1_v,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wdata,
  input  lane_en_t      wbyte_en,
  output logic          commit_v,
  output logic [AW-1:0] commit_addr,
  output word_t         commit_d0,
  output lane_en_t      commit_be0,
  output word_t         commit_d1,
  output lane_en_t      commit_be1,
  input  logic [AW-1:0] raddr,
  input  word_t         base,
  output word_t         fwd
);
  logic          h_v;
  logic [AW-1:0] h_addr;
  word_t         h_d0, h_d1;
  lane_en_t      h_be0, h_be1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_v    <= 1'b0;
      h_addr <= '0;
      h_d0   <= '0;
      h_d1   <= '0;
      h_be0  <= '0;
      h_be1  <= '0;
    end else if (wr_b0_v) begin
      h_v    <= 1'b1;
      h_addr <= wr_addr;
      h_d0   <= wdata;
      h_be0  <= wbyte_en;
      h_be1  <= '0;
    end else if (wr_b1_v) begin
      h_d1   <= wdata;
      h_be1  <= wbyte_en;
    end
  end

  // the previous write is committed as the next one lands
  assign commit_v    = wr_b0_v & h_v;
  assign commit_addr = h_addr;
  assign commit_d0   = h_d0;
  assign commit_be0  = h_be0;
  assign commit_d1   = h_d1;
  assign commit_be1  = h_be1;

  always_comb begin
    fwd = base;
    if (h_v && raddr == h_addr)
      fwd = lane_merge(base, h_d0, h_be0);
    else if (h_v && raddr == {h_addr[AW-1:1], ~h_addr[0]})
      fwd = lane_merge(base, h_d1, h_be1);
  end
endmodule

// File: rtl/b2ddr_rdout.sv
module b2ddr_rdout import b2ddr_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  word_t word,
  output word_t rdata,
  output logic  rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= take;
      rdata    <= take ? word : '0;
    end
  end
endmodule

// File: rtl/burst2_ddr_sram.sv
module burst2_ddr_sram import b2ddr_pkg::*; #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_half,
  input  logic          start_n,
  input  logic          rd_not_wr,
  input  logic [AW-1:0] addr,
  input  logic [17:0]   wdata,
  input  logic [1:0]    wbyte_en,
  output logic [17:0]   rdata,
  output logic          rd_valid
);
  logic          k_edge;
  logic          rd_b0_v, rd_b1_v, wr_b0_v, wr_b1_v;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          commit_v;
  logic [AW-1:0] commit_addr;
  word_t         commit_d0, commit_d1, arr_word, fwd_word;
  lane_en_t      commit_be0, commit_be1;

  b2ddr_cmdpipe #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .lat_half(lat_half), .start_n(start_n),
    .rd_not_wr(rd_not_wr), .addr(addr), .k_edge(k_edge),
    .rd_b0_v(rd_b0_v), .rd_b1_v(rd_b1_v), .rd_addr(rd_addr),
    .wr_b0_v(wr_b0_v), .wr_b1_v(wr_b1_v), .wr_addr(wr_addr)
  );

  b2ddr_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_b0_v(wr_b0_v), .wr_b1_v(wr_b1_v),
    .wr_addr(wr_addr), .wdata(wdata), .wbyte_en(wbyte_en),
    .commit_v(commit_v), .commit_addr(commit_addr),
    .commit_d0(commit_d0), .commit_be0(commit_be0),
    .commit_d1(commit_d1), .commit_be1(commit_be1),
    .raddr(rd_addr), .base(arr_word), .fwd(fwd_word)
  );

  b2ddr_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(commit_v), .waddr(commit_addr),
    .wd0(commit_d0), .wbe0(commit_be0), .wd1(commit_d1), .wbe1(commit_be1),
    .raddr(rd_addr), .rword(arr_word)
  );

  b2ddr_rdout u_out (
    .clk(clk), .rst_n(rst_n), .take(rd_b0_v | rd_b1_v), .word(fwd_word),
    .rdata(rdata), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/b2ddr_chk.sv
module b2ddr_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lat_half,
  input logic          start_n,
  input logic          rd_not_wr,
  input logic          k_edge,
  input logic          rd_b0_v,
  input logic          rd_b1_v,
  input logic          wr_b0_v,
  input logic [AW-1:0] commit_addr,
  input logic          rd_valid
);
  logic rd_cmd;
  assign rd_cmd = k_edge & ~start_n & rd_not_wr;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !rd_valid);

  // R4
  lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !lat_half) |-> ##3 rd_valid ##1 rd_valid);

  // R5
  lat_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && lat_half) |-> ##4 rd_valid ##1 rd_valid);

  // R9
  valid_src_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !lat_half) |-> ($past(rd_cmd, 3) || $past(rd_cmd, 4)));

  // R9
  valid_src_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && lat_half) |-> ($past(rd_cmd, 4) || $past(rd_cmd, 5)));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_b0_v |=> $stable(commit_addr));

  // R10
  one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_b0_v, rd_b1_v}));
endmodule

bind burst2_ddr_sram b2ddr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_half(lat_half), .start_n(start_n),
  .rd_not_wr(rd_not_wr), .k_edge(k_edge), .rd_b0_v(rd_b0_v),
  .rd_b1_v(rd_b1_v), .wr_b0_v(wr_b0_v), .commit_addr(commit_addr),
  .rd_valid(rd_valid)
);

// File: tb/burst2_ddr_sram_test.sv
module burst2_ddr_sram_test;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, lat_half = 1'b0, start_n = 1'b1, rd_not_wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0]   wdata = '0;
  logic [1:0]    wbyte_en = '0;
  logic [17:0]   rdata;
  logic          rd_valid;

  burst2_ddr_sram #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .lat_half(lat_half), .start_n(start_n),
    .rd_not_wr(rd_not_wr), .addr(addr), .wdata(wdata), .wbyte_en(wbyte_en),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  int n_checks = 0, n_errors = 0, cyc = 0;
  bit chk_en = 0, finished = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [17:0]   m_mem [NW];
  logic          hv;
  logic [AW-1:0] ha;
  logic [17:0]   hd0, hd1;
  logic [1:0]    hbe0, hbe1;
  int            e = 0;
  logic          cap_v [16];
  logic [AW-1:0] cap_a [16];
  logic          wb0 [16], wb1 [16];
  logic [AW-1:0] wba [16];
  logic          exp_v = 1'b0;
  logic [17:0]   exp_d = '0;
  logic          drv_v [16];
  logic [17:0]   drv_d [16];
  logic [1:0]    drv_be [16];

  function automatic logic [17:0] merge(input logic [17:0] b, input logic [17:0] u,
                                        input logic [1:0] en);
    logic [17:0] r = b;
    if (en[0]) r[8:0]  = u[8:0];
    if (en[1]) r[17:9] = u[17:9];
    return r;
  endfunction

  function automatic logic [17:0] mread(input logic [AW-1:0] a);
    if (hv && a == ha) return merge(m_mem[a], hd0, hbe0);
    if (hv && a == (ha ^ 1)) return merge(m_mem[a], hd1, hbe1);
    return m_mem[a];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; hv = 0; ha = '0; hd0 = '0; hd1 = '0; hbe0 = '0; hbe1 = '0;
      exp_v = 0; exp_d = '0;
      for (int i = 0; i < NW; i++) m_mem[i] = '0;
      for (int i = 0; i < 16; i++) begin
        cap_v[i] = 0; wb0[i] = 0; wb1[i] = 0; drv_v[i] = 0;
      end
    end else begin
      int s;
      s = e % 16;
      if (cap_v[s]) begin exp_v = 1; exp_d = mread(cap_a[s]); end
      else begin exp_v = 0; exp_d = '0; end
      cap_v[s] = 0;
      if (wb0[s]) begin
        if (hv) begin
          m_mem[ha]     = merge(m_mem[ha], hd0, hbe0);
          m_mem[ha ^ 1] = merge(m_mem[ha ^ 1], hd1, hbe1);
        end
        hv = 1; ha = wba[s]; hd0 = wdata; hbe0 = wbyte_en; hbe1 = '0;
      end
      if (wb1[s]) begin hd1 = wdata; hbe1 = wbyte_en; end
      wb0[s] = 0; wb1[s] = 0;
      if (e % 2 == 0 && !start_n) begin
        if (rd_not_wr) begin
          int l;
          l = lat_half ? 1 : 0;
          cap_v[(e + 2 + l) % 16] = 1; cap_a[(e + 2 + l) % 16] = addr;
          cap_v[(e + 3 + l) % 16] = 1; cap_a[(e + 3 + l) % 16] = addr ^ 1;
        end else begin
          wb0[(e + 2) % 16] = 1; wba[(e + 2) % 16] = addr;
          wb1[(e + 3) % 16] = 1;
        end
      end
      e = e + 1;
    end
  end

  // write data driver: scheduled beats, junk elsewhere
  always @(negedge clk) begin
    if (rst_n && drv_v[e % 16]) begin
      wdata = drv_d[e % 16]; wbyte_en = drv_be[e % 16]; drv_v[e % 16] = 0;
    end else begin
      wdata = 18'h2AAAA ^ 18'(e * 37); wbyte_en = 2'b11;
    end
  end

  always @(negedge clk) begin
    if (chk_en && !finished) begin
      n_checks++;
      if (rd_valid !== exp_v || rdata !== exp_d) begin
        n_errors++;
        $display("FAIL %s edge %0d: actual valid=%b data=%h expected valid=%b data=%h",
                 cur_req, e, rd_valid, rdata, exp_v, exp_d);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic issue(input logic r, input logic [AW-1:0] a,
                       input logic [17:0] d0, input logic [1:0] b0,
                       input logic [17:0] d1, input logic [1:0] b1);
    @(negedge clk);
    while (e % 2 != 0) begin start_n = 1; @(negedge clk); end
    start_n = 0; rd_not_wr = r; addr = a;
    if (!r) begin
      drv_v[(e + 2) % 16] = 1; drv_d[(e + 2) % 16] = d0; drv_be[(e + 2) % 16] = b0;
      drv_v[(e + 3) % 16] = 1; drv_d[(e + 3) % 16] = d1; drv_be[(e + 3) % 16] = b1;
    end
    @(negedge clk);
    start_n = 1; rd_not_wr = ~r; addr = a + 6'd17;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [17:0] d0, input logic [1:0] b0,
                    input logic [17:0] d1, input logic [1:0] b1);
    issue(1'b0, a, d0, b0, d1, b1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    issue(1'b1, a, '0, '0, '0, '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk) start_n = 1;
  endtask

  task automatic odd_junk(input logic r, input logic [AW-1:0] a);
    @(negedge clk);
    while (e % 2 != 1) @(negedge clk);
    start_n = 0; rd_not_wr = r; addr = a;
    @(negedge clk);
    start_n = 1;
  endtask

  initial begin
    cur_req = "R1";
    repeat (2) @(posedge clk);
    #1 chk_en = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle(4);

    cur_req = "R6";
    wr(6'd2, 18'h11111, 2'b11, 18'h02222, 2'b11);
    wr(6'd5, 18'h33333, 2'b11, 18'h04444, 2'b11);
    wr(6'd8, 18'h15555, 2'b11, 18'h26666, 2'b11);
    idle(4);
    cur_req = "R4";
    rd(6'd2);
    idle(6);
    cur_req = "R3";
    rd(6'd5);
    idle(6);

    cur_req = "R6";
    wr(6'd8, 18'h3FFFF, 2'b01, 18'h3FFFF, 2'b10);
    cur_req = "R7";
    wr(6'd20, 18'h0ABCD, 2'b11, 18'h1BCDE, 2'b11);
    idle(4);
    rd(6'd8);
    idle(6);

    cur_req = "R8";
    wr(6'd12, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11);
    wr(6'd30, 18'h01234, 2'b11, 18'h05678, 2'b11);
    wr(6'd12, 18'h00000, 2'b10, 18'h00000, 2'b01);
    rd(6'd12);
    rd(6'd13);
    idle(6);

    cur_req = "R10";
    rd(6'd2); rd(6'd4); rd(6'd8); rd(6'd21);
    wr(6'd40, 18'h00101, 2'b11, 18'h00202, 2'b11);
    wr(6'd42, 18'h00303, 2'b11, 18'h00404, 2'b01);
    rd(6'd41); wr(6'd44, 18'h00505, 2'b10, 18'h00606, 2'b11);
    rd(6'd42); rd(6'd44); rd(6'd45);
    idle(6);

    cur_req = "R2";
    odd_junk(1'b0, 6'd2);
    odd_junk(1'b1, 6'd8);
    idle(6);
    rd(6'd2); rd(6'd3);
    idle(6);

    cur_req = "R5";
    lat_half = 1;
    idle(2);
    rd(6'd8); rd(6'd45);
    wr(6'd50, 18'h2468A, 2'b11, 18'h13579, 2'b10);
    rd(6'd51);
    idle(8);

    cur_req = "R9";
    idle(6);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule